// File: doc/BRIEF.md
# Debug Address Watchpoint Matcher

This block watches a 64-bit address stream for debug events. Software loads up to four addresses into comparison slots, chooses per slot whether the slot catches an instruction fetch, data writes only, or any data read or write, and selects a span of 1, 2, 4 or 8 bytes. Every cycle one CPU access is offered (address, byte size, access kind), and it is compared against every armed slot at once. On a hit the block raises a one-cycle trap in the following cycle and sets one sticky status bit per slot that hit.

Each slot has two enables. The per-task enable is cleared by a task-switch pulse. The persistent enable survives a task switch. A general-detect bit in the control word protects the debug registers: while it is set, any register write is discarded and raises the trap instead. All state is reached through an indexed register port whose reads return data one cycle later.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset all slot addresses, the control word and the status word are zero, `trap` is 0 and `reg_rdata` is 0.
- R2: A write with `reg_idx` 0..3 loads that slot address; index 6 loads status bits 3:0; index 7 loads the control word, where only bits 0..7, 13 and 16..31 are stored and all other bits read as zero. A read returns the addressed value in `reg_rdata` in the next cycle, taken before any write in the same cycle. `reg_rdata` is 0 in a cycle after no read.
- R3: Indices 4 and 5 always read as zero, and writes to them change no register.
- R4: Slot i is armed when control bit 2i (per-task enable) or bit 2i+1 (persistent enable) is 1. A slot that is not armed never hits.
- R5: Access kind encoding on `acc_kind`: 00 fetch, 01 data read, 10 data write, 11 no access. A slot with access type 00 (control bits 16+4i..17+4i) and length 00 (bits 18+4i..19+4i) hits only a fetch whose address equals the slot address exactly. Access type 00 with a nonzero length never hits.
- R6: Access type 01 hits data writes only; 11 hits data reads and writes; 10 never hits. A data slot never hits a fetch.
- R7: Length 00 spans 1 byte, 01 spans 2 bytes, 11 spans 4 bytes, 10 spans 8 bytes; the slot address is rounded down to a multiple of the span. Access size encoding on `acc_size`: 00 1 byte, 01 2, 10 4, 11 8. A data slot hits when the access byte range overlaps the slot span.
- R8: `trap` is 1 for exactly the cycle after an access that hit at least one slot, and the status bit of every slot that hit is set, so several bits may be set by one access.
- R9: Status bits are sticky: they clear only through a status write, and a hit in the same cycle as a status write still sets its bit.
- R10: A `task_switch` pulse clears control bits 0, 2, 4 and 6 and leaves bits 1, 3, 5 and 7 unchanged. It is applied after a control write in the same cycle.
- R11: While control bit 13 (general detect) is 1, every register write is discarded and `trap` is 1 in the next cycle. Register reads still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register index 0..7 |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data, one cycle after the read |
| acc_valid | input | 1 | An access is offered this cycle |
| acc_addr | input | 64 | Access start address |
| acc_size | input | 2 | Access size code |
| acc_kind | input | 2 | Access kind code |
| task_switch | input | 1 | Task-switch pulse |
| trap | output | 1 | Debug trap pulse |

## Verification
The bench goes after the span edges: an access that ends one byte before a rounded-down 8-byte span, and one that straddles into it. A matcher that skipped the rounding, or compared start addresses only, would miss the straddle or catch the near miss. It checks that a fetch never hits a data slot and that the I/O type never hits; a wrong type decoder would trap on the wrong kind. It also covers a status clear colliding with a fresh hit, a task switch colliding with a control write, and general-detect writes that must leave every register untouched. A design that got these orderings wrong would lose a status bit, keep a stale per-task enable, or let a protected register change.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;

  // control word field positions
  localparam int GD_BIT       = 13;
  localparam int RW_BASE      = 16;
  localparam int LEN_BASE     = 18;
  localparam int FIELD_STRIDE = 4;

  // register indices with fixed meaning
  localparam int STATUS_IDX = 6;
  localparam int CTRL_IDX   = 7;

  typedef enum logic [1:0] {
    RW_FETCH = 2'b00,
    RW_WRITE = 2'b01,
    RW_IO    = 2'b10,
    RW_RDWR  = 2'b11
  } rw_e;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_NONE  = 2'b11
  } kind_e;

  // log2 of the byte span selected by a length code
  function automatic logic [1:0] span_log2(input logic [1:0] len);
    case (len)
      2'b00:   span_log2 = 2'd0;
      2'b01:   span_log2 = 2'd1;
      2'b11:   span_log2 = 2'd2;
      default: span_log2 = 2'd3;
    endcase
  endfunction

  function automatic logic kind_passes(input logic [1:0] rw, input logic [1:0] kind);
    case (rw)
      RW_WRITE: kind_passes = (kind == KIND_WRITE);
      RW_RDWR:  kind_passes = (kind == KIND_READ) || (kind == KIND_WRITE);
      default:  kind_passes = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbg_slot_match.sv
module dbg_slot_match
  import dbg_watch_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              armed,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic [1:0]        rw,
  input  logic [1:0]        len,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [1:0]        acc_kind,
  output logic              hit
);

  localparam int XW = ADDR_W + 1;

  logic [1:0]    slog;
  logic [XW-1:0] span;
  logic [XW-1:0] s_lo;
  logic [XW-1:0] s_hi;
  logic [XW-1:0] a_lo;
  logic [XW-1:0] a_hi;
  logic          overlap;
  logic          inst_hit;
  logic          data_hit;

  always_comb begin
    slog = span_log2(len);
    span = XW'(1) << slog;
    s_lo = {1'b0, slot_addr} & ~(span - XW'(1));
    s_hi = s_lo + span - XW'(1);
    a_lo = {1'b0, acc_addr};
    a_hi = a_lo + (XW'(1) << acc_size) - XW'(1);
    overlap = (a_lo <= s_hi) && (a_hi >= s_lo);
  end

  assign inst_hit = armed && acc_valid && (rw == RW_FETCH) && (len == 2'b00) &&
                    (acc_kind == KIND_FETCH) && (acc_addr == slot_addr);
  assign data_hit = armed && acc_valid && kind_passes(rw, acc_kind) && overlap;
  assign hit      = inst_hit || data_hit;

endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
  import dbg_watch_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [IDX_W-1:0]            reg_idx,
  input  logic [DATA_W-1:0]           reg_wdata,
  input  logic                        task_switch,
  input  logic [NUM_SLOTS-1:0]        hit_vec,
  output logic [DATA_W-1:0]           ctrl_q,
  output logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_flat,
  output logic [NUM_SLOTS-1:0]        status_q,
  output logic [DATA_W-1:0]           rdata,
  output logic                        gd_block
);

  function automatic logic [DATA_W-1:0] keep_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      m[2*i]   = 1'b1;
      m[2*i+1] = 1'b1;
      for (int b = 0; b < FIELD_STRIDE; b++) m[RW_BASE + FIELD_STRIDE*i + b] = 1'b1;
    end
    m[GD_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] local_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SLOTS; i++) m[2*i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] KEEP  = keep_mask();
  localparam logic [DATA_W-1:0] LOCAL = local_mask();

  logic              wr_ok;
  logic              wr_ctrl;
  logic              wr_status;
  logic [DATA_W-1:0] ctrl_d;
  logic [NUM_SLOTS-1:0] status_d;
  logic [DATA_W-1:0] rd_val;

  assign gd_block  = reg_wr && ctrl_q[GD_BIT];
  assign wr_ok     = reg_wr && !ctrl_q[GD_BIT];
  assign wr_ctrl   = wr_ok && (reg_idx == IDX_W'(CTRL_IDX));
  assign wr_status = wr_ok && (reg_idx == IDX_W'(STATUS_IDX));

  always_comb begin
    ctrl_d = wr_ctrl ? (reg_wdata & KEEP) : ctrl_q;
    if (task_switch) ctrl_d = ctrl_d & ~LOCAL;
    status_d = (wr_status ? reg_wdata[NUM_SLOTS-1:0] : status_q) | hit_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      status_q <= status_d;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_addr_flat[s*ADDR_W +: ADDR_W] <= '0;
      else if (wr_ok && (reg_idx == IDX_W'(s)))
        slot_addr_flat[s*ADDR_W +: ADDR_W] <= reg_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (reg_idx == IDX_W'(s)) rd_val = DATA_W'(slot_addr_flat[s*ADDR_W +: ADDR_W]);
    if (reg_idx == IDX_W'(STATUS_IDX)) rd_val = DATA_W'(status_q);
    if (reg_idx == IDX_W'(CTRL_IDX))   rd_val = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= reg_rd ? rd_val : '0;
  end

endmodule

// File: rtl/dbg_trap_gen.sv
module dbg_trap_gen #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] hit_vec,
  input  logic                 gd_block,
  output logic                 trap
);

  always_ff @(posedge clk) begin
    if (!rst_n) trap <= 1'b0;
    else        trap <= (|hit_vec) || gd_block;
  end

endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [1:0]        acc_kind,
  input  logic              task_switch,
  output logic              trap
);

  logic [DATA_W-1:0]           ctrl_q;
  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_flat;
  logic [NUM_SLOTS-1:0]        status_q;
  logic [NUM_SLOTS-1:0]        hit_vec;
  logic                        gd_block;

  dbg_reg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .task_switch(task_switch),
    .hit_vec(hit_vec), .ctrl_q(ctrl_q), .slot_addr_flat(slot_addr_flat),
    .status_q(status_q), .rdata(reg_rdata), .gd_block(gd_block)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic armed;
    assign armed = ctrl_q[2*s] || ctrl_q[2*s+1];
    dbg_slot_match #(.ADDR_W(ADDR_W)) match_i (
      .armed(armed),
      .slot_addr(slot_addr_flat[s*ADDR_W +: ADDR_W]),
      .rw(ctrl_q[RW_BASE + FIELD_STRIDE*s +: 2]),
      .len(ctrl_q[LEN_BASE + FIELD_STRIDE*s +: 2]),
      .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_size(acc_size), .acc_kind(acc_kind),
      .hit(hit_vec[s])
    );
  end

  dbg_trap_gen #(.NUM_SLOTS(NUM_SLOTS)) trap_i (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec),
    .gd_block(gd_block), .trap(trap)
  );

endmodule

// File: rtl/dbg_watch_unit_chk.sv
module dbg_watch_unit_chk
  import dbg_watch_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [IDX_W-1:0]     reg_idx,
  input logic                 task_switch,
  input logic                 acc_valid,
  input logic                 trap,
  input logic [DATA_W-1:0]    reg_rdata,
  input logic [DATA_W-1:0]    ctrl_q,
  input logic [NUM_SLOTS-1:0] status_q,
  input logic [NUM_SLOTS-1:0] hit_vec
);

  function automatic logic [DATA_W-1:0] en_mask(input int odd);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SLOTS; i++) m[2*i+odd] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] LOC_M = en_mask(0);
  localparam logic [DATA_W-1:0] GLB_M = en_mask(1);

  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_idx == IDX_W'(4) || reg_idx == IDX_W'(5))) |=> (reg_rdata == '0));

  assert_disarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q & (LOC_M | GLB_M)) == '0) |-> (hit_vec == '0));

  assert_trap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(acc_valid || reg_wr));

  assert_hit_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> ((status_q & $past(hit_vec)) == $past(hit_vec)));

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_idx == IDX_W'(STATUS_IDX)) |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_ts_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> ((ctrl_q & LOC_M) == '0));

  assert_ts_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (task_switch && !(reg_wr && reg_idx == IDX_W'(CTRL_IDX))) |=> ((ctrl_q & GLB_M) == $past(ctrl_q & GLB_M)));

  assert_gd_trap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ctrl_q[GD_BIT]) |=> trap);

  assert_gd_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ctrl_q[GD_BIT] && !task_switch) |=> $stable(ctrl_q));

endmodule

bind dbg_watch_unit dbg_watch_unit_chk #(
  .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_idx(reg_idx), .task_switch(task_switch), .acc_valid(acc_valid),
  .trap(trap), .reg_rdata(reg_rdata), .ctrl_q(ctrl_q),
  .status_q(status_q), .hit_vec(hit_vec)
);

// File: tb/dbg_watch_unit_tb_top.sv
module dbg_watch_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [63:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [1:0]  acc_kind = 2'b11;
  logic        task_switch = 1'b0;
  logic        trap;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural model state
  logic [63:0] m_addr [4];
  logic [63:0] m_ctrl = '0;
  logic [3:0]  m_stat = '0;

  dbg_watch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_kind(acc_kind), .task_switch(task_switch), .trap(trap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] model_read(input int idx);
    if (idx < 4) return m_addr[idx];
    if (idx == 6) return {60'd0, m_stat};
    if (idx == 7) return m_ctrl;
    return 64'd0;
  endfunction

  function automatic bit slot_hits(input int i);
    logic [1:0] rw, len;
    int lg, nbytes;
    rw  = m_ctrl[16 + 4*i +: 2];
    len = m_ctrl[18 + 4*i +: 2];
    if (!acc_valid || !(m_ctrl[2*i] || m_ctrl[2*i+1])) return 0;
    if (rw == 2'b00)
      return (len == 2'b00) && (acc_kind == 2'b00) && (acc_addr == m_addr[i]);
    if (!((rw == 2'b01 && acc_kind == 2'b10) ||
          (rw == 2'b11 && (acc_kind == 2'b01 || acc_kind == 2'b10)))) return 0;
    lg = (len == 2'b00) ? 0 : (len == 2'b01) ? 1 : (len == 2'b11) ? 2 : 3;
    nbytes = 1 << acc_size;
    for (int k = 0; k < nbytes; k++)
      if (((acc_addr + 64'(k)) >> lg) == (m_addr[i] >> lg)) return 1;
    return 0;
  endfunction

  // apply the inputs already driven for one clock and compare
  task automatic cycle(input string tag);
    logic [3:0]  hits;
    logic        e_trap;
    logic [63:0] e_rd;
    bit          gd;
    for (int i = 0; i < 4; i++) hits[i] = slot_hits(i);
    gd     = m_ctrl[13];
    e_rd   = reg_rd ? model_read(int'(reg_idx)) : 64'd0;
    e_trap = (hits != 0) || (reg_wr && gd);
    if (reg_wr && !gd) begin
      if (reg_idx < 3'd4) m_addr[reg_idx] = reg_wdata;
      else if (reg_idx == 3'd6) m_stat = reg_wdata[3:0];
      else if (reg_idx == 3'd7) m_ctrl = reg_wdata & 64'hFFFF_20FF;
    end
    if (task_switch) m_ctrl = m_ctrl & ~64'h55;
    m_stat = m_stat | hits;
    @(posedge clk);
    #1;
    vectors++;
    if (trap !== e_trap || reg_rdata !== e_rd) begin
      miscompares++;
      $display("FAIL %s: trap=%0b rdata=%h expected trap=%0b rdata=%h",
               tag, trap, reg_rdata, e_trap, e_rd);
    end
    reg_wr = 0; reg_rd = 0; acc_valid = 0; acc_kind = 2'b11; task_switch = 0;
  endtask

  task automatic wr(input int idx, input logic [63:0] d, input string tag);
    reg_wr = 1; reg_idx = 3'(idx); reg_wdata = d; cycle(tag);
  endtask

  task automatic rd(input int idx, input string tag);
    reg_rd = 1; reg_idx = 3'(idx); cycle(tag);
  endtask

  task automatic acc(input logic [63:0] a, input logic [1:0] sz, input logic [1:0] k, input string tag);
    acc_valid = 1; acc_addr = a; acc_size = sz; acc_kind = k; cycle(tag);
  endtask

  function automatic logic [63:0] slot_cfg(input int i, input bit l, input bit g,
                                           input logic [1:0] rw, input logic [1:0] len);
    return (64'(l) << (2*i)) | (64'(g) << (2*i+1)) |
           (64'(rw) << (16 + 4*i)) | (64'(len) << (18 + 4*i));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_addr[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (trap !== 1'b0 || reg_rdata !== 64'd0) begin
      miscompares++;
      $display("FAIL R1: trap=%0b rdata=%h expected trap=0 rdata=0", trap, reg_rdata);
    end
    rst_n = 1;
    for (int i = 0; i < 8; i++) rd(i, "R1 reset value");

    // R2 register port
    wr(0, 64'h0000_1234_5678_1000, "R2 write slot0");
    rd(0, "R2 readback slot0");
    wr(3, 64'hFFFF_0000_0000_0003, "R2 write slot3");
    rd(3, "R2 readback slot3");
    wr(7, 64'hFFFF_DFFF_FFFF_DFFF, "R2 control mask");
    rd(7, "R2 control readback");
    wr(7, 64'd0, "R2 control clear");
    reg_rd = 1; reg_idx = 3'd0; reg_wr = 1; reg_wdata = 64'h2000;
    cycle("R2 read before same-cycle write");
    rd(0, "R2 new value after write");
    cycle("R2 idle rdata zero");

    // R3 reserved indices
    wr(4, 64'hDEAD, "R3 write idx4");
    wr(5, 64'hBEEF, "R3 write idx5");
    rd(4, "R3 read idx4");
    rd(5, "R3 read idx5");
    for (int i = 0; i < 8; i++) rd(i, "R3 registers untouched");

    // R5 instruction slot
    wr(0, 64'h4000, "R5 slot0 address");
    wr(7, slot_cfg(0, 1, 0, 2'b00, 2'b00), "R5 arm fetch slot");
    acc(64'h4000, 2'b00, 2'b00, "R5 exact fetch hits");
    cycle("R8 trap is a pulse");
    acc(64'h4001, 2'b00, 2'b00, "R5 fetch off by one");
    acc(64'h4000, 2'b00, 2'b01, "R5 read at fetch slot");
    acc(64'h4000, 2'b11, 2'b11, "R5 no-access kind");
    rd(6, "R8 status after fetch hit");
    wr(6, 64'd0, "R9 status clear");
    rd(6, "R9 status cleared");
    wr(7, slot_cfg(0, 1, 0, 2'b00, 2'b01), "R5 fetch with nonzero length");
    acc(64'h4000, 2'b00, 2'b00, "R5 nonzero length never hits");

    // R4 arming
    wr(7, slot_cfg(0, 0, 0, 2'b00, 2'b00), "R4 disarm");
    acc(64'h4000, 2'b00, 2'b00, "R4 disarmed slot silent");
    wr(7, slot_cfg(0, 0, 1, 2'b00, 2'b00), "R4 persistent enable");
    acc(64'h4000, 2'b00, 2'b00, "R4 persistent enable hits");

    // R6 access types
    wr(1, 64'h8000, "R6 slot1 address");
    wr(7, slot_cfg(1, 0, 1, 2'b01, 2'b11), "R6 write-only 4B");
    acc(64'h8002, 2'b00, 2'b10, "R6 write hits");
    acc(64'h8002, 2'b00, 2'b01, "R6 read ignored by write-only");
    wr(7, slot_cfg(1, 0, 1, 2'b11, 2'b11), "R6 read-write");
    acc(64'h8003, 2'b00, 2'b01, "R6 read hits");
    acc(64'h8000, 2'b00, 2'b00, "R6 fetch ignored by data slot");
    wr(7, slot_cfg(1, 0, 1, 2'b10, 2'b11), "R6 io type");
    acc(64'h8000, 2'b10, 2'b10, "R6 io type never hits");
    acc(64'h8000, 2'b10, 2'b01, "R6 io type never hits read");

    // R7 spans and rounding
    wr(2, 64'h9005, "R7 misaligned slot2");
    wr(7, slot_cfg(2, 1, 0, 2'b11, 2'b10), "R7 8-byte span");
    acc(64'h9000, 2'b11, 2'b01, "R7 full span");
    acc(64'h8FFE, 2'b01, 2'b01, "R7 ends just before span");
    acc(64'h8FFF, 2'b01, 2'b10, "R7 straddles into span");
    acc(64'h9008, 2'b00, 2'b01, "R7 just past span");
    acc(64'h9007, 2'b00, 2'b01, "R7 last byte");
    acc(64'h8FF8, 2'b11, 2'b01, "R7 neighbour quadword");
    wr(7, slot_cfg(2, 1, 0, 2'b11, 2'b01), "R7 2-byte span");
    acc(64'h9006, 2'b00, 2'b01, "R7 2-byte miss");
    acc(64'h9004, 2'b00, 2'b01, "R7 2-byte rounded hit");
    wr(7, slot_cfg(2, 1, 0, 2'b11, 2'b11), "R7 4-byte span");
    acc(64'h9003, 2'b00, 2'b01, "R7 4-byte miss");
    acc(64'h9007, 2'b00, 2'b01, "R7 4-byte top byte");
    wr(7, slot_cfg(2, 1, 0, 2'b11, 2'b00), "R7 1-byte span");
    acc(64'h9004, 2'b00, 2'b01, "R7 1-byte miss");
    acc(64'h9004, 2'b01, 2'b01, "R7 1-byte covered by wider access");

    // R8 several slots on one access
    wr(6, 64'd0, "R8 clear status");
    wr(0, 64'hA000, "R8 slot0");
    wr(3, 64'hA004, "R8 slot3");
    wr(7, slot_cfg(0, 1, 0, 2'b11, 2'b11) | slot_cfg(3, 0, 1, 2'b01, 2'b10),
       "R8 two overlapping slots");
    acc(64'hA002, 2'b01, 2'b10, "R8 double hit");
    cycle("R8 pulse ends");
    rd(6, "R8 two status bits");
    acc(64'hA002, 2'b01, 2'b01, "R8 read hits only slot0");

    // R9 sticky and collision
    repeat (3) cycle("R9 idle");
    rd(6, "R9 status still set");
    reg_wr = 1; reg_idx = 3'd6; reg_wdata = 64'd0;
    acc_valid = 1; acc_addr = 64'hA006; acc_size = 2'b00; acc_kind = 2'b10;
    cycle("R9 clear collides with hit");
    rd(6, "R9 hit wins over clear");

    // R10 task switch
    wr(7, slot_cfg(0, 1, 1, 2'b11, 2'b11) | slot_cfg(1, 1, 0, 2'b11, 2'b11) |
          slot_cfg(3, 0, 1, 2'b01, 2'b10), "R10 mixed enables");
    task_switch = 1; cycle("R10 task switch");
    rd(7, "R10 locals cleared, globals kept");
    reg_wr = 1; reg_idx = 3'd7; reg_wdata = 64'h0000_0000_00FF; task_switch = 1;
    cycle("R10 switch with control write");
    rd(7, "R10 switch applied after write");
    wr(1, 64'h8000, "R10 slot1 address");
    acc(64'h8000, 2'b00, 2'b01, "R10 cleared local slot silent");

    // R11 general detect
    wr(0, 64'hC000, "R11 slot0 before protect");
    wr(7, 64'h2000 | slot_cfg(0, 1, 1, 2'b11, 2'b11), "R11 set general detect");
    wr(0, 64'hFFFF, "R11 protected write traps");
    rd(0, "R11 address unchanged");
    wr(7, 64'd0, "R11 control write dropped");
    rd(7, "R11 control unchanged");
    wr(6, 64'hF, "R11 status write dropped");
    rd(6, "R11 status unchanged");
    task_switch = 1; cycle("R11 task switch still clears");
    rd(7, "R11 control after switch");
    acc(64'hC001, 2'b00, 2'b01, "R11 matching still works");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule